// File: doc/BRIEF.md
# Scatter-Gather Resume Point Finder

This block takes a descriptor table of scatter-gather entries and a byte offset into the transfer they describe. It finds the entry that holds that offset and streams out the rest of the transfer as address/length segments. A job starts with a one-cycle start strobe that carries a command option word, a command table base address and a byte offset. The entry count sits in the top 16 bits of the option word. The table starts 0x80 bytes past the command table base. Each entry is 16 bytes long: a 64-bit buffer address, a reserved word, and a zero-based 32-bit size.

Entries are read one at a time over a request/response port that allows a single read in flight. While searching, the block keeps a running total of the lengths of the entries before the current one. The first emitted segment is the chosen entry with the leading part already consumed by the offset cut away. Every entry after it goes out unchanged. Each segment waits for the consumer's ready. A done strobe ends the job, and an error flag marks jobs that have no valid resume point.

Top module: `sg_offset_locator`

## Requirements
- R1: A start with an entry count of zero (option word bits 31:16) makes no memory request. It raises done and err together in the cycle after the start is sampled and leaves the block idle.
- R2: Entry k is read at address base + 0x80 + 16*k. Reads are issued in ascending k, one in flight at a time. A request holds its valid and address until it is accepted.
- R3: A read response carries the entry's buffer address in bits 63:0 and its size field in bits 127:96. Bits 95:64 are ignored. The entry's byte length is the size field plus one, computed without overflow up to 2^32.
- R4: The chosen entry is the first k for which offset <= S(k) + len(k), where S(k) is the sum of the lengths of entries 0..k-1.
- R5: The first segment has address addr(k) + (offset - S(k)) and length len(k) - (offset - S(k)). An offset that lands exactly on the end of an entry picks that entry and gives a zero-length segment.
- R6: The entries after the chosen one, up to count-1, are emitted in order with their own address and full length.
- R7: When no entry qualifies, all count entries are read, no segment is emitted, and done and err are raised together.
- R8: While a segment is valid and not yet accepted, its valid, address and length stay unchanged.
- R9: After the last segment is accepted, done is high with err low for exactly one cycle, in the cycle right after the acceptance.
- R10: A start strobe while a job is in progress is ignored. The running job's outputs and its single done are unaffected.
- R11: After reset the block is idle, with no request, no segment, and done and err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled only when idle |
| opts_i | input | 32 | Command option word; entry count in bits 31:16 |
| tbl_base_i | input | 64 | Command table base address |
| offset_i | input | 32 | Byte offset at which to resume |
| busy_o | output | 1 | A job is in progress |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_addr_o | output | 64 | Byte address of the requested entry |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 128 | The 16-byte entry |
| seg_valid_o | output | 1 | Segment valid |
| seg_addr_o | output | 64 | Segment start address |
| seg_len_o | output | 33 | Segment length in bytes |
| seg_ready_i | input | 1 | Consumer accepts the segment |
| done_o | output | 1 | One-cycle end-of-job strobe |
| err_o | output | 1 | No resume point; high only with done |

## Verification
Assertions check, on every cycle, that requests and segments are held steady under back-pressure and that the two handshakes never overlap. They also check that err never appears without done, that a zero count ends the job on the next cycle, that done follows acceptance of the final segment, and that a start during a job leaves the captured job unchanged. Only the bench scenarios can show that the right entry is chosen and that the trimmed first segment and the unchanged later segments carry the right values. That covers offsets on an entry boundary, offsets one past it and offsets beyond the whole table, as well as the full 2^32 length of a maximum size field. The bench compares these against a reference walk it computes itself.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_EMIT = 2'd3
  } sgl_state_t;

endpackage

// File: rtl/sgl_addr_gen.sv
module sgl_addr_gen #(
  parameter int ADDR_W    = 64,
  parameter int CNT_W     = 16,
  parameter int TBL_OFS   = 128,
  parameter int DESC_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(TBL_OFS);

  logic [ADDR_W-1:0] stride;

  always_comb begin
    stride = ADDR_W'(idx_i) << DESC_LOG2;
    addr_o = base_i + OFS + stride;
  end

endmodule

// File: rtl/sgl_seg_calc.sv
module sgl_seg_calc #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 32,
  parameter int OFF_W  = 32,
  parameter int SUM_W  = 49
) (
  input  logic [ADDR_W-1:0] ent_addr_i,
  input  logic [SIZE_W-1:0] ent_size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SUM_W-1:0]  sum_i,
  output logic [SIZE_W:0]   ent_len_o,
  output logic [SUM_W-1:0]  sum_next_o,
  output logic              hit_o,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [SIZE_W:0]   first_len_o
);

  localparam int LEN_W = SIZE_W + 1;

  logic [SUM_W-1:0] off_ext;
  logic [LEN_W-1:0] pos;

  always_comb begin
    ent_len_o    = LEN_W'(ent_size_i) + LEN_W'(1);
    off_ext      = SUM_W'(off_i);
    sum_next_o   = sum_i + SUM_W'(ent_len_o);
    hit_o        = (off_ext <= sum_next_o);
    pos          = LEN_W'(off_ext - sum_i);
    first_addr_o = ent_addr_i + ADDR_W'(pos);
    first_len_o  = ent_len_o - pos;
  end

endmodule

// File: rtl/sg_offset_locator.sv
module sg_offset_locator
  import sgl_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int OPT_W     = 32,
  parameter int CNT_W     = 16,
  parameter int OFF_W     = 32,
  parameter int SIZE_W    = 32,
  parameter int DATA_W    = 128,
  parameter int TBL_OFS   = 128,
  parameter int DESC_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       opts_i,
  input  logic [63:0]       tbl_base_i,
  input  logic [31:0]       offset_i,
  output logic              busy_o,
  output logic              mem_req_valid_o,
  output logic [63:0]       mem_req_addr_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [127:0]      mem_rsp_data_i,
  output logic              seg_valid_o,
  output logic [63:0]       seg_addr_o,
  output logic [32:0]       seg_len_o,
  input  logic              seg_ready_i,
  output logic              done_o,
  output logic              err_o
);

  localparam int LEN_W = SIZE_W + 1;
  localparam int SUM_W = SIZE_W + CNT_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  sgl_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, idx_q, idx_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [SUM_W-1:0]  sum_q, sum_d;
  logic              srch_q, srch_d;
  logic [ADDR_W-1:0] sega_q, sega_d;
  logic [LEN_W-1:0]  segl_q, segl_d;
  logic              done_q, done_d, err_q, err_d;

  logic [CNT_W-1:0]  cnt_in;
  logic              is_last;
  logic [ADDR_W-1:0] ent_addr, first_addr;
  logic [SIZE_W-1:0] ent_size;
  logic [LEN_W-1:0]  ent_len, first_len;
  logic [SUM_W-1:0]  sum_next;
  logic              hit;
  logic              rsvd_unused;

  assign cnt_in      = opts_i[OPT_W-1 -: CNT_W];
  assign ent_addr    = mem_rsp_data_i[ADDR_W-1:0];
  assign ent_size    = mem_rsp_data_i[DATA_W-1 -: SIZE_W];
  assign rsvd_unused = ^{mem_rsp_data_i[DATA_W-SIZE_W-1:ADDR_W], opts_i[OPT_W-CNT_W-1:0]};
  assign is_last     = (idx_q == cnt_q - CNT_W'(1));

  sgl_addr_gen #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TBL_OFS(TBL_OFS), .DESC_LOG2(DESC_LOG2)
  ) u_addr (
    .base_i(base_q), .idx_i(idx_q), .addr_o(mem_req_addr_o)
  );

  sgl_seg_calc #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W), .SUM_W(SUM_W)
  ) u_calc (
    .ent_addr_i(ent_addr), .ent_size_i(ent_size), .off_i(off_q), .sum_i(sum_q),
    .ent_len_o(ent_len), .sum_next_o(sum_next), .hit_o(hit),
    .first_addr_o(first_addr), .first_len_o(first_len)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    base_d  = base_q;
    off_d   = off_q;
    sum_d   = sum_q;
    srch_d  = srch_q;
    sega_d  = sega_q;
    segl_d  = segl_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cnt_d  = cnt_in;
          base_d = tbl_base_i;
          off_d  = offset_i;
          idx_d  = '0;
          sum_d  = '0;
          srch_d = 1'b1;
          if (cnt_in == '0) begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            state_d = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (mem_req_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid_i) begin
          if (!srch_q) begin
            sega_d  = ent_addr;
            segl_d  = ent_len;
            state_d = ST_EMIT;
          end else if (hit) begin
            sega_d  = first_addr;
            segl_d  = first_len;
            srch_d  = 1'b0;
            state_d = ST_EMIT;
          end else begin
            sum_d = sum_next;
            if (is_last) begin
              done_d  = 1'b1;
              err_d   = 1'b1;
              state_d = ST_IDLE;
            end else begin
              idx_d   = idx_q + CNT_W'(1);
              state_d = ST_REQ;
            end
          end
        end
      end
      ST_EMIT: begin
        if (seg_ready_i) begin
          if (is_last) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            idx_d   = idx_q + CNT_W'(1);
            state_d = ST_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      base_q  <= '0;
      off_q   <= '0;
      sum_q   <= '0;
      srch_q  <= 1'b0;
      sega_q  <= '0;
      segl_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      off_q   <= off_d;
      sum_q   <= sum_d;
      srch_q  <= srch_d;
      sega_q  <= sega_d;
      segl_q  <= segl_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign seg_valid_o     = (state_q == ST_EMIT);
  assign seg_addr_o      = sega_q;
  assign seg_len_o       = segl_q;
  assign done_o          = done_q;
  assign err_o           = err_q;

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R8
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o));

  // R2
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !(mem_req_valid_o && seg_valid_o));

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    err_o |-> done_o);

  // R1
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy_o && start_i && (cnt_in == '0) |=> done_o && err_o && !busy_o && !mem_req_valid_o);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    seg_valid_o && seg_ready_i && is_last |=> done_o && !err_o && !busy_o);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy_o && start_i |=> $stable(cnt_q) && $stable(off_q) && $stable(base_q));

endmodule

// File: tb/sg_offset_locator_bench.sv
`timescale 1ns/1ps
module sg_offset_locator_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [31:0]  opts_i = '0;
  logic [63:0]  tbl_base_i = '0;
  logic [31:0]  offset_i = '0;
  logic         busy_o;
  logic         mem_req_valid_o;
  logic [63:0]  mem_req_addr_o;
  logic         mem_req_ready_i = 1'b0;
  logic         mem_rsp_valid_i = 1'b0;
  logic [127:0] mem_rsp_data_i = '0;
  logic         seg_valid_o;
  logic [63:0]  seg_addr_o;
  logic [32:0]  seg_len_o;
  logic         seg_ready_i = 1'b0;
  logic         done_o;
  logic         err_o;

  always #2.5 clk = ~clk;

  sg_offset_locator u_sg_offset_locator (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opts_i(opts_i),
    .tbl_base_i(tbl_base_i), .offset_i(offset_i), .busy_o(busy_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .seg_valid_o(seg_valid_o),
    .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o), .seg_ready_i(seg_ready_i),
    .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int fails  = 0;

  // descriptor table seen by the memory model
  longint unsigned ent_a [64];
  int unsigned     ent_s [64];
  longint unsigned cur_base = 0;

  // expected results
  longint unsigned exp_a [64];
  longint unsigned exp_l [64];

  // logs written only at the rising edge
  longint unsigned req_log [4096];
  longint unsigned sa_log  [4096];
  longint unsigned sl_log  [4096];
  int  req_n = 0, seg_n = 0, done_n = 0, hold_bad = 0;
  int  cyc = 0, seg_last_cyc = 0, done_cyc = 0;
  bit  done_err = 0;
  bit  pv = 0, pr = 0;
  longint unsigned pa = 0, pl = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mem_req_valid_o && mem_req_ready_i) begin
        req_log[req_n & 4095] <= mem_req_addr_o;
        req_n <= req_n + 1;
      end
      if (seg_valid_o && seg_ready_i) begin
        sa_log[seg_n & 4095] <= seg_addr_o;
        sl_log[seg_n & 4095] <= 64'(seg_len_o);
        seg_n <= seg_n + 1;
        seg_last_cyc <= cyc;
      end
      if (done_o) begin
        done_n   <= done_n + 1;
        done_err <= err_o;
        done_cyc <= cyc;
      end
      if (pv && !pr && (!seg_valid_o || seg_addr_o != pa || 64'(seg_len_o) != pl))
        hold_bad <= hold_bad + 1;
      pv <= seg_valid_o;
      pr <= seg_ready_i;
      pa <= seg_addr_o;
      pl <= 64'(seg_len_o);
    end
  end

  function automatic logic [127:0] rd_ent(longint unsigned a);
    longint unsigned i;
    i = (a - cur_base - 64'd128) >> 4;
    if (i < 64) return {ent_s[i], 32'h5A5A_0F0F, ent_a[i]};
    return '1;
  endfunction

  // memory model and back-pressure, driven on the falling edge
  int served = 0;
  int dly = 0;
  always @(negedge clk) begin
    mem_rsp_valid_i = 1'b0;
    if (served < req_n) begin
      if (dly == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = rd_ent(req_log[served & 4095]);
        served = served + 1;
        dly = int'($urandom % 3);
      end else begin
        dly = dly - 1;
      end
    end
    mem_req_ready_i = ($urandom % 4) != 0;
    seg_ready_i     = ($urandom % 3) != 0;
  end

  task automatic check(input bit ok, input string r, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // reference walk
  task automatic calc(input int cnt, input longint unsigned off,
                      output int ecnt, output bit eerr);
    longint unsigned sum = 0;
    longint unsigned len;
    int found = -1;
    ecnt = 0;
    eerr = 1'b1;
    for (int i = 0; i < cnt; i++) begin
      len = 64'(ent_s[i]) + 1;
      if (off <= sum + len) begin
        found = i;
        exp_a[0] = ent_a[i] + (off - sum);
        exp_l[0] = len - (off - sum);
        break;
      end
      sum += len;
    end
    if (found >= 0) begin
      eerr = 1'b0;
      ecnt = 1;
      for (int j = found + 1; j < cnt; j++) begin
        exp_a[ecnt] = ent_a[j];
        exp_l[ecnt] = 64'(ent_s[j]) + 1;
        ecnt++;
      end
    end
  endtask

  task automatic run_job(input int cnt, input longint unsigned off,
                         input longint unsigned base, input bit poke);
    int s0 = seg_n, r0 = req_n, d0 = done_n;
    int ecnt, sc, t;
    bit eerr, aok;
    calc(cnt, off, ecnt, eerr);
    cur_base = base;
    @(negedge clk);
    opts_i     = {cnt[15:0], 16'h0A5C};
    offset_i   = off[31:0];
    tbl_base_i = base;
    start_i    = 1'b1;
    sc = cyc;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      opts_i = '0;
      offset_i = 32'hFFFF_FFFF;
      tbl_base_i = '1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    while (done_n == d0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(done_n - d0 == 1, poke ? "R10 single done" : "R9 single done", 64'(done_n - d0), 1);
    check(done_err == eerr, eerr ? "R7 err flag" : "R9 err flag", 64'(done_err), 64'(eerr));
    check(seg_n - s0 == ecnt, eerr ? "R7 segment count" : "R6 segment count",
          64'(seg_n - s0), 64'(ecnt));
    for (int i = 0; i < ecnt && i < seg_n - s0; i++) begin
      check(sa_log[(s0 + i) & 4095] == exp_a[i], i == 0 ? "R4 R5 first addr" : "R6 addr",
            sa_log[(s0 + i) & 4095], exp_a[i]);
      check(sl_log[(s0 + i) & 4095] == exp_l[i], i == 0 ? "R5 first len" : "R6 R3 len",
            sl_log[(s0 + i) & 4095], exp_l[i]);
    end
    check(req_n - r0 == cnt, cnt == 0 ? "R1 no request" : "R2 request count",
          64'(req_n - r0), 64'(cnt));
    aok = 1'b1;
    for (int i = 0; i < cnt && i < req_n - r0; i++)
      if (req_log[(r0 + i) & 4095] != base + 128 + 64'(i) * 16) aok = 1'b0;
    check(aok, "R2 request addresses", 64'(aok), 1);
    if (cnt == 0)
      check(done_cyc == sc + 1, "R1 done timing", 64'(done_cyc), 64'(sc + 1));
    else if (!eerr)
      check(done_cyc == seg_last_cyc + 1, "R9 done timing", 64'(done_cyc), 64'(seg_last_cyc + 1));
    check(!busy_o, "R9 idle after done", 64'(busy_o), 0);
  endtask

  initial begin
    int unsigned sd;
    longint unsigned tot;
    int cnt;
    sd = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(!busy_o && !mem_req_valid_o && !seg_valid_o && !done_o && !err_o,
          "R11 reset state", {59'd0, busy_o, mem_req_valid_o, seg_valid_o, done_o, err_o}, 0);

    ent_a[0] = 64'h0000_1000_0000_0000; ent_s[0] = 99;
    ent_a[1] = 64'h0000_2000_0000_0100; ent_s[1] = 0;
    ent_a[2] = 64'hFFFF_0000_1234_5000; ent_s[2] = 49;
    ent_a[3] = 64'h0000_0003_0000_0000; ent_s[3] = 32'hFFFF_FFFF;
    for (int i = 4; i < 64; i++) begin
      ent_a[i] = {$urandom, $urandom};
      ent_s[i] = $urandom % 500;
    end

    run_job(0, 5, 64'h8000, 1'b0);             // R1
    run_job(3, 0, 64'h1_0000, 1'b0);           // R4 start of table
    run_job(3, 100, 64'h1_0000, 1'b0);         // R5 boundary, zero length
    run_job(3, 101, 64'h2_0000, 1'b0);         // R4 one past boundary
    run_job(3, 102, 64'h2_0000, 1'b0);         // R5 inside entry 2
    run_job(3, 151, 64'h3_0000, 1'b0);         // R5 end of table
    run_job(3, 152, 64'h3_0000, 1'b0);         // R7 beyond table
    run_job(4, 156, 64'h4_0000, 1'b0);         // R3 full-size entry
    run_job(1, 7, 64'h5_0000, 1'b0);           // single entry
    run_job(6, 10, 64'h6_0000, 1'b1);          // R10 start while busy

    for (int r = 0; r < 30; r++) begin
      cnt = 1 + int'($urandom % 8);
      for (int i = 0; i < cnt; i++) begin
        ent_a[i] = {$urandom, $urandom};
        ent_s[i] = ($urandom % 5 == 0) ? 0 : $urandom % 300;
      end
      tot = 0;
      for (int i = 0; i < cnt; i++) tot += 64'(ent_s[i]) + 1;
      run_job(cnt, 64'($urandom % 32'(tot + 20)), {32'h0, $urandom & 32'hFFFF_FFF0},
              (cnt >= 3) && (r % 4 == 0));
    end

    // R8 hold under back-pressure
    check(hold_bad == 0, "R8 segment hold", 64'(hold_bad), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule